// File: doc/BRIEF.md
# Byte-Serial Handshake Output Controller

This block stands between the result register of a converter and a narrow shared bus. It holds a 24-bit conversion result and hands it out as three 8-bit bytes. It has two modes.

In direct mode the host owns the select lines. The host drives a chip select and three byte-enable inputs, and it reads whichever byte it likes. In handshake mode, which a low-to-high change of the mode pin starts, the block drives the byte strobes and a load strobe itself. It sends the high byte, then the middle byte, then the low byte. Each byte goes out only on a clock edge where the receiver's send-enable is high. While a handshake transfer is in progress, new conversion results are not taken, so the bytes cannot change partway through. When the low byte has gone out, the block drops back to direct mode by itself.

The strobe, load and data pins are modelled as a value plus an output-enable. A board-level pull-up is assumed to hold the released strobe pins high. All outputs are registered, and the reset is synchronous and active high.

Top module: `hs_byte_out`

## Requirements
- R1: Handshake mode is entered only on a low-to-high change of `mode_pin` seen after reset. The pin passes through two synchroniser flops. If the pin changes between edges k-1 and k, `strobe_oe` is high from edge k+2. A level held through reset never enters handshake mode.
- R2: In direct mode, `strobe_oe` is low and `byte_en` and `load_stb` are zero.
- R3: In handshake mode, each rising edge where `send_en` is sampled high presents one byte for exactly one clock: `data_oe`=1, `load_stb`=1 and exactly one `byte_en` bit set. An edge where `send_en` is low presents nothing (`data_oe`=0, `byte_en`=0) and keeps the sequence position.
- R4: Handshake bytes go out in the order high, middle, low. The high byte is `byte_en`=3'b100 with result bits 23:16. The middle byte is 3'b010 with bits 15:8. The low byte is 3'b001 with bits 7:0.
- R5: `conv_done` at an edge where the mode is direct copies `result_in` into the result register. This includes the edge on which handshake mode takes effect, and that captured value is the one sent. From the next edge until the mode is direct again, `conv_done` is ignored.
- R6: The edge after the low byte is presented returns the block to direct mode: `strobe_oe` and `data_oe` go low. `conv_done` on that same edge is still ignored, and latching works again from the following edge.
- R7: `status_o` equals `conv_done` delayed by one clock, in both modes.
- R8: In direct mode, an edge with `host_sel`=1 and `host_byte_en` nonzero gives `data_oe`=1 in the next cycle, with `data_o` set to the byte of the highest set enable bit (bit i selects result bits 8i+7:8i). Any other combination gives `data_oe`=0 and `data_o`=0. Host select inputs are ignored in handshake mode.
- R9: While `rst` is high at an edge, every output goes low. The result register clears and the mode becomes direct.
- R10: A new rising edge on `mode_pin` during a handshake transfer neither restarts nor extends the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous power-on clear, active high |
| mode_pin | input | 1 | Asynchronous mode request; a rising edge starts a handshake transfer |
| send_en | input | 1 | Receiver ready; one byte is sent per edge where it is high |
| conv_done | input | 1 | One-cycle pulse: a new conversion result is available |
| result_in | input | 24 | Conversion result |
| host_sel | input | 1 | Host chip select (direct mode) |
| host_byte_en | input | 3 | Host byte enables, bit 2 high byte (direct mode) |
| data_o | output | 8 | Bus data value |
| data_oe | output | 1 | Bus data drive enable; low means high impedance |
| byte_en | output | 3 | Byte strobes driven in handshake mode |
| strobe_oe | output | 1 | Drive enable for `byte_en` and `load_stb` |
| load_stb | output | 1 | Load strobe to the receiver, one pulse per byte |
| status_o | output | 1 | Conversion status, delayed `conv_done` |

## Verification
Result capture and mode changes can fall on the same clock edge. The bench pulses `conv_done` on the exact edge where handshake mode takes effect, in the middle of transfers with different stall patterns, and on the edge where the sequence finishes. Each case is judged by the bytes that appear on the bus, during the transfer and in direct reads afterwards. The bytes must be the value captured at entry, never a value that arrived later. A second collision, a fresh mode-pin edge in the middle of a stalled transfer, is judged by the next byte: it must be the middle byte and not the high byte again.

// File: rtl/hbo_pkg.sv
package hbo_pkg;

  typedef enum logic [1:0] {
    ST_DIRECT = 2'd0,
    ST_SEND   = 2'd1,
    ST_DONE   = 2'd2
  } hs_state_e;

endpackage

// File: rtl/hbo_edge_sync.sv
module hbo_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  output logic rise
);

  logic [STAGES-1:0] sync_q;
  logic              last_q;

  // Preset to ones: a level that is already high at reset is not an edge.
  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '1;
      last_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], pin};
      last_q <= sync_q[STAGES-1];
    end
  end

  assign rise = sync_q[STAGES-1] & ~last_q;

endmodule

// File: rtl/hbo_result_reg.sv
module hbo_result_reg #(
  parameter int RES_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_allow,
  input  logic             conv_done,
  input  logic [RES_W-1:0] result_in,
  output logic [RES_W-1:0] res_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      res_q <= '0;
    end else if (conv_done && load_allow) begin
      res_q <= result_in;
    end
  end

endmodule

// File: rtl/hbo_sequencer.sv
module hbo_sequencer
  import hbo_pkg::*;
#(
  parameter int NB    = 3,
  parameter int IDX_W = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rise,
  input  logic             send_en,
  output hs_state_e        state,
  output hs_state_e        nxt_state,
  output logic             present,
  output logic [IDX_W-1:0] idx
);

  localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(NB - 1);

  logic [IDX_W-1:0] ptr_q;

  always_comb begin
    nxt_state = state;
    present   = 1'b0;
    unique case (state)
      ST_DIRECT: if (rise) nxt_state = ST_SEND;
      ST_SEND: begin
        if (send_en) begin
          present = 1'b1;
          if (ptr_q == '0) nxt_state = ST_DONE;
        end
      end
      ST_DONE: nxt_state = ST_DIRECT;
      default: nxt_state = ST_DIRECT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_DIRECT;
      ptr_q <= TOP_IDX;
    end else begin
      state <= nxt_state;
      if (state == ST_DIRECT) ptr_q <= TOP_IDX;
      else if (present)       ptr_q <= ptr_q - 1'b1;
    end
  end

  assign idx = ptr_q;

endmodule

// File: rtl/hbo_out_stage.sv
module hbo_out_stage
  import hbo_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int NB     = 3,
  parameter int IDX_W  = (NB > 1) ? $clog2(NB) : 1,
  parameter int RES_W  = BYTE_W * NB
) (
  input  logic              clk,
  input  logic              rst,
  input  hs_state_e         state,
  input  hs_state_e         nxt_state,
  input  logic              present,
  input  logic [IDX_W-1:0]  idx,
  input  logic              host_sel,
  input  logic [NB-1:0]     host_byte_en,
  input  logic [RES_W-1:0]  res_q,
  output logic [BYTE_W-1:0] data_o,
  output logic              data_oe,
  output logic [NB-1:0]     byte_en,
  output logic              strobe_oe,
  output logic              load_stb
);

  logic             host_hit;
  logic [IDX_W-1:0] host_idx;
  logic             host_read;

  // Highest set enable wins.
  always_comb begin
    host_hit = 1'b0;
    host_idx = '0;
    for (int i = 0; i < NB; i++) begin
      if (host_byte_en[i]) begin
        host_hit = 1'b1;
        host_idx = IDX_W'(i);
      end
    end
  end

  assign host_read = (state == ST_DIRECT) && (nxt_state == ST_DIRECT) &&
                     host_sel && host_hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      data_o    <= '0;
      data_oe   <= 1'b0;
      byte_en   <= '0;
      strobe_oe <= 1'b0;
      load_stb  <= 1'b0;
    end else begin
      strobe_oe <= (nxt_state != ST_DIRECT);
      if (present) begin
        data_oe  <= 1'b1;
        data_o   <= res_q[idx*BYTE_W +: BYTE_W];
        byte_en  <= NB'(1) << idx;
        load_stb <= 1'b1;
      end else if (host_read) begin
        data_oe  <= 1'b1;
        data_o   <= res_q[host_idx*BYTE_W +: BYTE_W];
        byte_en  <= '0;
        load_stb <= 1'b0;
      end else begin
        data_oe  <= 1'b0;
        data_o   <= '0;
        byte_en  <= '0;
        load_stb <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/hs_byte_out.sv
module hs_byte_out
  import hbo_pkg::*;
#(
  parameter int BYTE_W      = 8,
  parameter int NUM_BYTES   = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          mode_pin,
  input  logic                          send_en,
  input  logic                          conv_done,
  input  logic [BYTE_W*NUM_BYTES-1:0]   result_in,
  input  logic                          host_sel,
  input  logic [NUM_BYTES-1:0]          host_byte_en,
  output logic [BYTE_W-1:0]             data_o,
  output logic                          data_oe,
  output logic [NUM_BYTES-1:0]          byte_en,
  output logic                          strobe_oe,
  output logic                          load_stb,
  output logic                          status_o
);

  localparam int RES_W = BYTE_W * NUM_BYTES;
  localparam int IDX_W = (NUM_BYTES > 1) ? $clog2(NUM_BYTES) : 1;

  logic             mode_rise;
  hs_state_e        state;
  hs_state_e        nxt_state;
  logic             present;
  logic [IDX_W-1:0] idx;
  logic [RES_W-1:0] res_q;

  hbo_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .pin  (mode_pin),
    .rise (mode_rise)
  );

  hbo_sequencer #(.NB(NUM_BYTES), .IDX_W(IDX_W)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .rise      (mode_rise),
    .send_en   (send_en),
    .state     (state),
    .nxt_state (nxt_state),
    .present   (present),
    .idx       (idx)
  );

  hbo_result_reg #(.RES_W(RES_W)) u_res (
    .clk        (clk),
    .rst        (rst),
    .load_allow (state == ST_DIRECT),
    .conv_done  (conv_done),
    .result_in  (result_in),
    .res_q      (res_q)
  );

  hbo_out_stage #(.BYTE_W(BYTE_W), .NB(NUM_BYTES), .IDX_W(IDX_W), .RES_W(RES_W)) u_out (
    .clk          (clk),
    .rst          (rst),
    .state        (state),
    .nxt_state    (nxt_state),
    .present      (present),
    .idx          (idx),
    .host_sel     (host_sel),
    .host_byte_en (host_byte_en),
    .res_q        (res_q),
    .data_o       (data_o),
    .data_oe      (data_oe),
    .byte_en      (byte_en),
    .strobe_oe    (strobe_oe),
    .load_stb     (load_stb)
  );

  always_ff @(posedge clk) begin
    if (rst) status_o <= 1'b0;
    else     status_o <= conv_done;
  end

endmodule

// File: rtl/hs_byte_out_chk.sv
module hs_byte_out_chk #(
  parameter int BYTE_W    = 8,
  parameter int NUM_BYTES = 3
) (
  input logic                        clk,
  input logic                        rst,
  input logic                        mode_pin,
  input logic                        conv_done,
  input logic                        data_oe,
  input logic [NUM_BYTES-1:0]        byte_en,
  input logic                        strobe_oe,
  input logic                        load_stb,
  input logic                        status_o,
  input logic [BYTE_W*NUM_BYTES-1:0] res_q
);

  AST_ENTRY_NEEDS_EDGE: assert property (@(posedge clk) disable iff (rst) $rose(strobe_oe) |-> $past(mode_pin, 3)); // R1
  AST_DIRECT_QUIET: assert property (@(posedge clk) disable iff (rst) !strobe_oe |-> (byte_en == '0 && !load_stb)); // R2
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst) (strobe_oe && data_oe) |-> ($countones(byte_en) == 1)); // R3
  AST_LOAD_WITH_BYTE: assert property (@(posedge clk) disable iff (rst) strobe_oe |-> (load_stb == data_oe)); // R3
  AST_RESULT_FROZEN: assert property (@(posedge clk) disable iff (rst) (strobe_oe && $past(strobe_oe)) |-> $stable(res_q)); // R5
  AST_STATUS_SET: assert property (@(posedge clk) disable iff (rst) conv_done |=> status_o); // R7
  AST_STATUS_CLR: assert property (@(posedge clk) disable iff (rst) !conv_done |=> !status_o); // R7

endmodule

bind hs_byte_out hs_byte_out_chk #(.BYTE_W(BYTE_W), .NUM_BYTES(NUM_BYTES)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .mode_pin  (mode_pin),
  .conv_done (conv_done),
  .data_oe   (data_oe),
  .byte_en   (byte_en),
  .strobe_oe (strobe_oe),
  .load_stb  (load_stb),
  .status_o  (status_o),
  .res_q     (res_q)
);

// File: tb/hs_byte_out_test.sv
module hs_byte_out_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mode_pin = 1'b0;
  logic        send_en = 1'b0;
  logic        conv_done = 1'b0;
  logic [23:0] result_in = '0;
  logic        host_sel = 1'b0;
  logic [2:0]  host_byte_en = '0;
  logic [7:0]  data_o;
  logic        data_oe;
  logic [2:0]  byte_en;
  logic        strobe_oe;
  logic        load_stb;
  logic        status_o;

  int n_chk  = 0;
  int n_fail = 0;
  logic [23:0] exp_res;

  hs_byte_out uut (
    .clk(clk), .rst(rst), .mode_pin(mode_pin), .send_en(send_en),
    .conv_done(conv_done), .result_in(result_in), .host_sel(host_sel),
    .host_byte_en(host_byte_en), .data_o(data_o), .data_oe(data_oe),
    .byte_en(byte_en), .strobe_oe(strobe_oe), .load_stb(load_stb),
    .status_o(status_o)
  );

  always #2 clk = ~clk;

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [7:0] byte_of(input logic [23:0] v, input int i);
    return v[i*8 +: 8];
  endfunction

  task automatic latch(input logic [23:0] v);
    result_in = v; conv_done = 1'b1;
    tick();
    conv_done = 1'b0;
    exp_res = v;
    check("R7 status after conv_done", int'(status_o), 1);
  endtask

  task automatic dread(input logic [2:0] e, input logic [23:0] ref_v, input string tag);
    int hi;
    hi = e[2] ? 2 : (e[1] ? 1 : 0);
    host_sel = 1'b1; host_byte_en = e;
    tick();
    host_sel = 1'b0; host_byte_en = '0;
    check({tag, " data_oe"}, int'(data_oe), 1);
    check({tag, " data"}, int'(data_o), int'(byte_of(ref_v, hi)));
  endtask

  task automatic enter_hs(input bit cap, input logic [23:0] v);
    mode_pin = 1'b0;
    repeat (3) tick();
    mode_pin = 1'b1;
    tick();
    check("R1 not yet after one edge", int'(strobe_oe), 0);
    tick();
    check("R1 not yet after two edges", int'(strobe_oe), 0);
    if (cap) begin result_in = v; conv_done = 1'b1; end
    tick();
    conv_done = 1'b0;
    if (cap) exp_res = v;
    check("R1 entry on third edge", int'(strobe_oe), 1);
  endtask

  initial begin
    #(4 * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    exp_res = '0;
    // R9: reset, with the mode pin already high (level must not enter: R1)
    mode_pin = 1'b1;
    rst = 1'b1;
    tick(); tick();
    check("R9 data_oe after reset", int'(data_oe), 0);
    check("R9 strobe_oe after reset", int'(strobe_oe), 0);
    check("R9 byte_en after reset", int'(byte_en), 0);
    check("R9 load_stb after reset", int'(load_stb), 0);
    check("R9 status after reset", int'(status_o), 0);
    rst = 1'b0;
    repeat (6) tick();
    check("R1 held level does not enter", int'(strobe_oe), 0);
    dread(3'b100, 24'h0, "R9 result cleared");

    // R8, R2: sweep of all host select combinations
    latch(24'hA1B2C3);
    for (int s = 0; s < 2; s++) begin
      for (int e = 0; e < 8; e++) begin
        logic hit;
        int   bi;
        hit = (s == 1) && (e != 0);
        bi = (e >= 4) ? 2 : ((e >= 2) ? 1 : 0);
        host_sel = s[0]; host_byte_en = e[2:0];
        tick();
        check("R8 direct data_oe", int'(data_oe), int'(hit));
        check("R8 direct data", int'(data_o), hit ? int'(byte_of(exp_res, bi)) : 0);
        check("R2 strobes released", int'(strobe_oe), 0);
        check("R2 byte_en zero", int'(byte_en), 0);
        check("R2 load_stb low", int'(load_stb), 0);
      end
    end
    host_sel = 1'b0; host_byte_en = '0;
    tick();

    // Transfers under every 4-bit stall pattern
    for (int p = 0; p < 16; p++) begin
      logic [23:0] va, vb, junk;
      int bidx;
      va = 24'(32'h135 * (p + 1) * 32'h1F3 ^ 32'hA5C3E1);
      vb = 24'(32'h2468AC ^ (p * 32'h10101));
      latch(va);
      enter_hs(p[0], vb);
      junk = ~exp_res;
      bidx = 2;
      for (int c = 0; c < 16 && bidx >= 0; c++) begin
        logic se;
        se = p[c % 4] | (c >= 8);
        send_en = se;
        host_sel = ~se; host_byte_en = se ? 3'b000 : 3'b111;
        if (c == (p % 4)) begin result_in = junk; conv_done = 1'b1; end
        tick();
        conv_done = 1'b0; send_en = 1'b0; host_sel = 1'b0; host_byte_en = '0;
        if (c == (p % 4)) check("R7 status in handshake", int'(status_o), 1);
        check("R3 strobes driven", int'(strobe_oe), 1);
        if (se) begin
          check("R3 byte presented", int'(data_oe), 1);
          check("R3 load strobe", int'(load_stb), 1);
          check("R4 byte order strobe", int'(byte_en), int'(3'b001 << bidx));
          check("R4 byte value frozen R5", int'(data_o), int'(byte_of(exp_res, bidx)));
          bidx--;
        end else begin
          check("R3 stall no data, R8 host ignored", int'(data_oe), 0);
          check("R3 stall no strobe", int'(byte_en), 0);
        end
      end
      // R6: finishing edge, with a conv_done that must be ignored
      result_in = junk; conv_done = 1'b1;
      tick();
      conv_done = 1'b0;
      check("R6 strobes released", int'(strobe_oe), 0);
      check("R6 bus released", int'(data_oe), 0);
      dread(3'b100, exp_res, "R5 high byte kept");
      dread(3'b010, exp_res, "R5 middle byte kept");
      dread(3'b001, exp_res, "R5 low byte kept");
      latch(va ^ 24'h5A5A5A);
      dread(3'b011, exp_res, "R6 latching resumed");
    end

    // R10: mode-pin edge during a stalled transfer does not restart it
    latch(24'h3C4D5E);
    enter_hs(1'b0, 24'h0);
    send_en = 1'b1;
    tick();
    send_en = 1'b0;
    check("R10 first byte high", int'(byte_en), 3'b100);
    mode_pin = 1'b0;
    repeat (3) tick();
    mode_pin = 1'b1;
    repeat (3) tick();
    check("R10 still in transfer", int'(strobe_oe), 1);
    check("R10 nothing sent while stalled", int'(data_oe), 0);
    send_en = 1'b1;
    tick();
    check("R10 continues with middle", int'(byte_en), 3'b010);
    check("R10 middle value", int'(data_o), int'(byte_of(exp_res, 1)));
    tick();
    send_en = 1'b0;
    check("R10 low byte", int'(byte_en), 3'b001);
    tick();
    check("R10 back to direct", int'(strobe_oe), 0);
    repeat (4) tick();
    check("R10 no re-entry from old edge", int'(strobe_oe), 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule